// File: doc/BRIEF.md
# Tone-Extension Antenna Switch and Sample Sequencer

This block runs the receive side of an angle-of-arrival capture. It waits for a single-cycle trigger that marks the end of a packet's CRC. It then counts incoming I/Q sample strobes, which arrive at four per microsecond symbol, through a settling interval of four symbols. After that it steps through one antenna switch slot per symbol. In each slot it drives a registered antenna-select output from a programmable pattern table. It forwards exactly one I/Q pair per slot, taken at a programmable sample position inside the slot, and tags that pair with the slot number and the antenna in use.

The configuration gives the number of slots, the pattern length, the pattern entries and the sample position inside a slot. The block takes a copy of the whole configuration when a capture starts. The capture ends once the kept sample of the last slot has been forwarded. A done pulse then reports how many slots were emitted. The RF switch, the converter and packet decoding are outside the block.

Top module: `aoa_slot_sequencer`

## Requirements
- R1: After reset, ant_sel_o is 0, out_vld_o is 0, done_o is 0 and done_slots_o is 0.
- R2: After a start pulse, the first 16 sample strobes (4 symbols of 4 strobes) form the settling interval. None of them is forwarded, and ant_sel_o holds 0 throughout.
- R3: After the settling interval, each group of 4 strobes is one slot. Strobe position p (0 to 3) in a slot is forwarded only when p equals cfg_pos_i. out_vld_o pulses in the cycle after that strobe and carries that strobe's I and Q values. Slot positions never produce two outputs in consecutive cycles.
- R4: ant_sel_o is registered. It changes only in the cycle after a strobe. It takes the table entry for slot k in the cycle after the last strobe of the window before it (the 16th settling strobe for slot 0, or the 4th strobe of slot k-1). Entry e of cfg_pattern_i occupies bits [e*ANT_W +: ANT_W].
- R5: The table index starts at 0 and advances by one per slot. It wraps to 0 when it reaches the pattern length. A length of 0 or 1 always selects entry 0. A length above the table depth acts as the depth.
- R6: Each forwarded pair carries out_slot_o, counted from 0, and out_ant_o, the antenna that ant_sel_o showed during that strobe.
- R7: A slot count of N yields exactly N forwarded pairs. A count of 0 yields none.
- R8: done_o is a one-cycle pulse. It comes one cycle after the last forwarded pair, or two cycles after the 16th settling strobe when the count is 0. done_slots_o then shows N. ant_sel_o returns to 0 right after the last kept strobe, and later strobes are ignored.
- R9: A start pulse that arrives while a capture is in progress is ignored.
- R10: The configuration is copied at the start pulse. Changes to the configuration inputs during a capture have no effect on that capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle trigger at the end of the packet CRC |
| iq_vld_i | input | 1 | Sample strobe, four per symbol |
| iq_i_i | input | IQ_W | In-phase sample |
| iq_q_i | input | IQ_W | Quadrature sample |
| cfg_len_i | input | LEN_W | Number of switch slots (extension length in symbols) |
| cfg_pat_len_i | input | $clog2(PAT_DEPTH+1) | Number of active pattern entries |
| cfg_pattern_i | input | PAT_DEPTH*ANT_W | Packed antenna pattern table |
| cfg_pos_i | input | $clog2(SPS) | Strobe position kept inside each slot |
| ant_sel_o | output | ANT_W | Registered antenna select |
| out_vld_o | output | 1 | Forwarded pair valid |
| out_i_o | output | IQ_W | Forwarded in-phase value |
| out_q_o | output | IQ_W | Forwarded quadrature value |
| out_slot_o | output | LEN_W | Slot number of the forwarded pair |
| out_ant_o | output | ANT_W | Antenna of the forwarded pair |
| done_o | output | 1 | Capture finished pulse |
| done_slots_o | output | LEN_W | Slots emitted by the last capture |

## Verification
The sensitive overlap is a kept sample that falls on the last strobe of a slot. That same edge must capture the sample with the old antenna tag and also step ant_sel_o to the next table entry. The bench provokes this with position 3 and with strobes on every clock, then compares each forwarded tag with the antenna the bench predicts for that slot. A second overlap is a start pulse that lands on a kept-sample edge or in the middle of the settling interval. It is judged by the forwarded stream staying identical to the undisturbed expectation, with exactly one done pulse.

// File: rtl/aoa_seq_pkg.sv
package aoa_seq_pkg;

    // Sequencer phases: idle, settling interval, switch slots, done report
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GUARD  = 2'd1,
        ST_SLOT   = 2'd2,
        ST_FINISH = 2'd3
    } seq_state_e;

endpackage

// File: rtl/aoa_pattern_store.sv
// Holds a copy of the antenna pattern taken at capture start; combinational read.
module aoa_pattern_store #(
    parameter int ANT_W     = 2,
    parameter int PAT_DEPTH = 16,
    parameter int PIDX_W    = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_i,
    input  logic [PAT_DEPTH*ANT_W-1:0] pattern_i,
    input  logic [PIDX_W-1:0]          rd_idx_i,
    output logic [ANT_W-1:0]           rd_ant_o
);

    logic [ANT_W-1:0] ent_q [PAT_DEPTH];

    for (genvar e = 0; e < PAT_DEPTH; e++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q[e] <= '0;
            end else if (load_i) begin
                ent_q[e] <= pattern_i[e*ANT_W +: ANT_W];
            end
        end
    end

    always_comb begin
        rd_ant_o = '0;
        for (int e = 0; e < PAT_DEPTH; e++) begin
            if (32'(rd_idx_i) == e) begin
                rd_ant_o = ent_q[e];
            end
        end
    end

endmodule

// File: rtl/aoa_iq_capture.sv
// Output register for the one kept I/Q pair of a slot with its tags.
module aoa_iq_capture #(
    parameter int IQ_W  = 12,
    parameter int LEN_W = 8,
    parameter int ANT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_i,
    input  logic [IQ_W-1:0]  i_i,
    input  logic [IQ_W-1:0]  q_i,
    input  logic [LEN_W-1:0] slot_i,
    input  logic [ANT_W-1:0] ant_i,
    output logic             vld_o,
    output logic [IQ_W-1:0]  i_o,
    output logic [IQ_W-1:0]  q_o,
    output logic [LEN_W-1:0] slot_o,
    output logic [ANT_W-1:0] ant_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_o  <= 1'b0;
            i_o    <= '0;
            q_o    <= '0;
            slot_o <= '0;
            ant_o  <= '0;
        end else begin
            vld_o <= take_i;
            if (take_i) begin
                i_o    <= i_i;
                q_o    <= q_i;
                slot_o <= slot_i;
                ant_o  <= ant_i;
            end
        end
    end

endmodule

// File: rtl/aoa_slot_sequencer.sv
module aoa_slot_sequencer
    import aoa_seq_pkg::*;
#(
    parameter int IQ_W       = 12,
    parameter int ANT_W      = 2,
    parameter int PAT_DEPTH  = 16,
    parameter int LEN_W      = 8,
    parameter int SPS        = 4,
    parameter int GUARD_SYMS = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start_i,
    input  logic                             iq_vld_i,
    input  logic [IQ_W-1:0]                  iq_i_i,
    input  logic [IQ_W-1:0]                  iq_q_i,
    input  logic [LEN_W-1:0]                 cfg_len_i,
    input  logic [$clog2(PAT_DEPTH+1)-1:0]   cfg_pat_len_i,
    input  logic [PAT_DEPTH*ANT_W-1:0]       cfg_pattern_i,
    input  logic [$clog2(SPS)-1:0]           cfg_pos_i,
    output logic [ANT_W-1:0]                 ant_sel_o,
    output logic                             out_vld_o,
    output logic [IQ_W-1:0]                  out_i_o,
    output logic [IQ_W-1:0]                  out_q_o,
    output logic [LEN_W-1:0]                 out_slot_o,
    output logic [ANT_W-1:0]                 out_ant_o,
    output logic                             done_o,
    output logic [LEN_W-1:0]                 done_slots_o
);

    localparam int POS_W   = $clog2(SPS);
    localparam int PLEN_W  = $clog2(PAT_DEPTH+1);
    localparam int PIDX_W  = (PAT_DEPTH > 1) ? $clog2(PAT_DEPTH) : 1;
    localparam int GUARD_N = SPS * GUARD_SYMS;
    localparam int GCNT_W  = $clog2(GUARD_N);

    typedef struct packed {
        seq_state_e         state;
        logic [GCNT_W-1:0]  gcnt;
        logic [POS_W-1:0]   pos;
        logic [LEN_W-1:0]   slot;
        logic [PIDX_W-1:0]  pidx;
        logic [ANT_W-1:0]   ant;
        logic [LEN_W-1:0]   len;
        logic [PLEN_W-1:0]  plen;
        logic [POS_W-1:0]   spos;
        logic               done;
        logic [LEN_W-1:0]   done_cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    logic              load_pat;
    logic [PIDX_W-1:0] rd_idx;
    logic [ANT_W-1:0]  rd_ant;
    logic              take;
    logic [PLEN_W:0]   idx_inc;
    logic              idx_wrap;
    logic [PIDX_W-1:0] idx_nxt;
    logic              guard_end;
    logic              slot_end;
    logic              last_slot;

    // Next table index with wrap at the latched pattern length
    assign idx_inc   = {1'b0, PLEN_W'(seq_q.pidx)} + (PLEN_W+1)'(1);
    assign idx_wrap  = idx_inc >= {1'b0, seq_q.plen};
    assign idx_nxt   = idx_wrap ? '0 : PIDX_W'(idx_inc);
    assign rd_idx    = (seq_q.state == ST_GUARD) ? '0 : idx_nxt;

    assign guard_end = seq_q.gcnt == GCNT_W'(GUARD_N-1);
    assign slot_end  = seq_q.pos == POS_W'(SPS-1);
    assign last_slot = seq_q.slot == (seq_q.len - LEN_W'(1));
    assign take      = (seq_q.state == ST_SLOT) && iq_vld_i && (seq_q.pos == seq_q.spos);
    assign load_pat  = (seq_q.state == ST_IDLE) && start_i;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.state = ST_GUARD;
                    seq_d.gcnt  = '0;
                    seq_d.pos   = '0;
                    seq_d.slot  = '0;
                    seq_d.pidx  = '0;
                    seq_d.ant   = '0;
                    seq_d.len   = cfg_len_i;
                    seq_d.plen  = (32'(cfg_pat_len_i) > PAT_DEPTH) ? PLEN_W'(PAT_DEPTH)
                                                                   : cfg_pat_len_i;
                    seq_d.spos  = cfg_pos_i;
                end
            end
            ST_GUARD: begin
                if (iq_vld_i) begin
                    if (guard_end) begin
                        if (seq_q.len == '0) begin
                            seq_d.state = ST_FINISH;
                        end else begin
                            seq_d.state = ST_SLOT;
                            seq_d.ant   = rd_ant;
                            seq_d.pidx  = '0;
                            seq_d.pos   = '0;
                            seq_d.slot  = '0;
                        end
                    end else begin
                        seq_d.gcnt = seq_q.gcnt + GCNT_W'(1);
                    end
                end
            end
            ST_SLOT: begin
                if (iq_vld_i) begin
                    if (take && last_slot) begin
                        seq_d.state = ST_FINISH;
                        seq_d.ant   = '0;
                    end else if (slot_end) begin
                        seq_d.pos  = '0;
                        seq_d.slot = seq_q.slot + LEN_W'(1);
                        seq_d.pidx = idx_nxt;
                        seq_d.ant  = rd_ant;
                    end else begin
                        seq_d.pos = seq_q.pos + POS_W'(1);
                    end
                end
            end
            ST_FINISH: begin
                seq_d.done     = 1'b1;
                seq_d.done_cnt = seq_q.len;
                seq_d.state    = ST_IDLE;
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    aoa_pattern_store #(
        .ANT_W     (ANT_W),
        .PAT_DEPTH (PAT_DEPTH),
        .PIDX_W    (PIDX_W)
    ) u_pat (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_pat),
        .pattern_i (cfg_pattern_i),
        .rd_idx_i  (rd_idx),
        .rd_ant_o  (rd_ant)
    );

    aoa_iq_capture #(
        .IQ_W  (IQ_W),
        .LEN_W (LEN_W),
        .ANT_W (ANT_W)
    ) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .take_i (take),
        .i_i    (iq_i_i),
        .q_i    (iq_q_i),
        .slot_i (seq_q.slot),
        .ant_i  (seq_q.ant),
        .vld_o  (out_vld_o),
        .i_o    (out_i_o),
        .q_o    (out_q_o),
        .slot_o (out_slot_o),
        .ant_o  (out_ant_o)
    );

    assign ant_sel_o    = seq_q.ant;
    assign done_o       = seq_q.done;
    assign done_slots_o = seq_q.done_cnt;

endmodule

// File: rtl/aoa_seq_checker.sv
module aoa_seq_checker #(
    parameter int ANT_W = 2,
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             iq_vld_i,
    input logic [ANT_W-1:0] ant_sel_o,
    input logic             out_vld_o,
    input logic             done_o,
    input logic [LEN_W-1:0] done_slots_o
);

    // R4: the antenna select moves only on the edge that took a strobe
    assert_ant_step_on_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ant_sel_o != $past(ant_sel_o)) |-> $past(iq_vld_i));

    // R3: a forwarded pair always follows a strobe
    assert_out_after_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld_o |-> $past(iq_vld_i));

    // R3: never two forwarded pairs back to back
    assert_out_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld_o |=> !out_vld_o);

    // R8: done is a single-cycle pulse
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: a non-empty capture reports done right after its last pair
    assert_done_after_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (done_slots_o != '0)) |-> $past(out_vld_o));

    // R8: no pair is forwarded together with done
    assert_done_no_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !out_vld_o);

endmodule

bind aoa_slot_sequencer aoa_seq_checker #(
    .ANT_W (ANT_W),
    .LEN_W (LEN_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .iq_vld_i     (iq_vld_i),
    .ant_sel_o    (ant_sel_o),
    .out_vld_o    (out_vld_o),
    .done_o       (done_o),
    .done_slots_o (done_slots_o)
);

// File: tb/sim_aoa_slot_sequencer.sv
module sim_aoa_slot_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        iq_vld_i = 1'b0;
    logic [11:0] iq_i_i = '0;
    logic [11:0] iq_q_i = '0;
    logic [7:0]  cfg_len_i = '0;
    logic [4:0]  cfg_pat_len_i = '0;
    logic [31:0] cfg_pattern_i = '0;
    logic [1:0]  cfg_pos_i = '0;
    logic [1:0]  ant_sel_o;
    logic        out_vld_o;
    logic [11:0] out_i_o;
    logic [11:0] out_q_o;
    logic [7:0]  out_slot_o;
    logic [1:0]  out_ant_o;
    logic        done_o;
    logic [7:0]  done_slots_o;

    always #10 clk = ~clk;

    aoa_slot_sequencer u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .iq_vld_i      (iq_vld_i),
        .iq_i_i        (iq_i_i),
        .iq_q_i        (iq_q_i),
        .cfg_len_i     (cfg_len_i),
        .cfg_pat_len_i (cfg_pat_len_i),
        .cfg_pattern_i (cfg_pattern_i),
        .cfg_pos_i     (cfg_pos_i),
        .ant_sel_o     (ant_sel_o),
        .out_vld_o     (out_vld_o),
        .out_i_o       (out_i_o),
        .out_q_o       (out_q_o),
        .out_slot_o    (out_slot_o),
        .out_ant_o     (out_ant_o),
        .done_o        (done_o),
        .done_slots_o  (done_slots_o)
    );

    typedef struct packed {
        logic [7:0]  slot;
        logic [1:0]  ant;
        logic [11:0] i;
        logic [11:0] q;
    } exp_t;

    exp_t exp_q[$];
    int   n_tests = 0;
    int   n_fail = 0;
    int   done_seen = 0;
    int   exp_len = 0;
    int   sample_base = 0;
    logic prev_vld = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int entry_of(input logic [31:0] pat, input int plen, input int k);
        int eff;
        int idx;
        eff = (plen > 16) ? 16 : plen;
        idx = (eff == 0) ? 0 : (k % eff);
        return int'(pat[idx*2 +: 2]);
    endfunction

    function automatic logic [11:0] i_val(input int n);
        return 12'(n);
    endfunction

    function automatic logic [11:0] q_val(input int n);
        return 12'(n) ^ 12'hA5A;
    endfunction

    // Monitor: pops the scoreboard on every forwarded pair, judges done pulses
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (out_vld_o) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R7", "unexpected forwarded pair, slot", int'(out_slot_o), -1);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        check(out_slot_o == e.slot, "R6", "slot tag", int'(out_slot_o), int'(e.slot));
                        check(out_ant_o == e.ant, "R6", "antenna tag", int'(out_ant_o), int'(e.ant));
                        check(out_i_o == e.i, "R3", "I value", int'(out_i_o), int'(e.i));
                        check(out_q_o == e.q, "R3", "Q value", int'(out_q_o), int'(e.q));
                    end
                end
                if (done_o) begin
                    done_seen++;
                    check(int'(done_slots_o) == exp_len, "R8", "done slot count",
                          int'(done_slots_o), exp_len);
                    check(exp_q.size() == 0, "R7", "pairs outstanding at done",
                          exp_q.size(), 0);
                    if (exp_len > 0) begin
                        check(prev_vld == 1'b1, "R8", "done one cycle after last pair",
                              int'(prev_vld), 1);
                    end
                end
                prev_vld = out_vld_o;
            end
        end
    end

    // Driver: one capture; pushes the expected pairs, then plays the strobes
    task automatic run_cap(input int len, input int plen, input logic [31:0] pat,
                           input int spos, input int gap, input bit disturb);
        int total;
        int d0;
        total = 16 + 4*len + 3;
        d0 = done_seen;
        cfg_len_i     = 8'(len);
        cfg_pat_len_i = 5'(plen);
        cfg_pattern_i = pat;
        cfg_pos_i     = 2'(spos);
        exp_len       = len;
        for (int k = 0; k < len; k++) begin
            exp_t e;
            int n;
            n = 16 + 4*k + spos;
            e.slot = 8'(k);
            e.ant  = 2'(entry_of(pat, plen, k));
            e.i    = i_val(sample_base + n);
            e.q    = q_val(sample_base + n);
            exp_q.push_back(e);
        end
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (disturb) begin
            // R10: configuration moves after the start pulse
            cfg_len_i     = 8'(len + 2);
            cfg_pat_len_i = 5'd1;
            cfg_pattern_i = ~pat;
            cfg_pos_i     = 2'((spos + 1) % 4);
        end
        @(negedge clk);
        for (int n = 0; n < total; n++) begin
            int exp_ant;
            int s;
            int p;
            if (n < 16) begin
                exp_ant = 0;
                check(ant_sel_o == 2'd0, "R2", "antenna during settling",
                      int'(ant_sel_o), 0);
            end else begin
                s = (n - 16) / 4;
                p = (n - 16) % 4;
                if (s < len && !(s == len - 1 && p > spos)) begin
                    exp_ant = entry_of(pat, plen, s);
                end else begin
                    exp_ant = 0;
                end
                check(int'(ant_sel_o) == exp_ant, "R4", "antenna at strobe",
                      int'(ant_sel_o), exp_ant);
            end
            iq_vld_i = 1'b1;
            iq_i_i   = i_val(sample_base + n);
            iq_q_i   = q_val(sample_base + n);
            // R9: start pulses while busy, mid-settling and on the last kept strobe
            if (disturb && (n == 5 || n == 16 + 4*(len-1) + spos)) begin
                start_i = 1'b1;
            end
            @(negedge clk);
            iq_vld_i = 1'b0;
            start_i  = 1'b0;
            repeat (gap) @(negedge clk);
        end
        sample_base += total;
        repeat (4) @(negedge clk);
        check(done_seen - d0 == 1, "R9", "done pulses for one capture", done_seen - d0, 1);
        check(exp_q.size() == 0, "R7", "pairs missing after capture", exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(ant_sel_o == 2'd0, "R1", "antenna after reset", int'(ant_sel_o), 0);
        check(out_vld_o == 1'b0, "R1", "valid after reset", int'(out_vld_o), 0);
        check(done_o == 1'b0, "R1", "done after reset", int'(done_o), 0);
        check(done_slots_o == 8'd0, "R1", "slot count after reset", int'(done_slots_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R3 R4: two antennas, 8 entries, first strobe kept, 4 MHz spacing
        run_cap(20, 8, 32'h0000_4444, 0, 11, 1'b0);
        // R5: three-entry table, last strobe kept (capture and step on one edge)
        run_cap(6, 3, 32'h0000_0039, 3, 2, 1'b0);
        // R5: strobes on every cycle, full table, second strobe kept
        run_cap(5, 16, 32'hE4E4_E4E4, 1, 0, 1'b0);
        // R7 R8: zero slots
        run_cap(0, 4, 32'h0000_00E4, 2, 1, 1'b0);
        // R5: length zero and length one keep entry 0
        run_cap(4, 0, 32'h0000_00E7, 2, 1, 1'b0);
        run_cap(4, 1, 32'h0000_00E6, 0, 1, 1'b0);
        // R5: length above depth acts as the depth
        run_cap(20, 31, 32'h1B1B_E4E4, 1, 0, 1'b0);
        // R9 R10: starts while busy and moving configuration
        run_cap(7, 3, 32'h0000_0027, 2, 3, 1'b1);
        // back-to-back capture after the disturbed one
        run_cap(3, 2, 32'h0000_000B, 3, 0, 1'b0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R8 watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule